// File: doc/BRIEF.md
# Management-Frame PHY Register Model

This block stands in for the register set of an Ethernet PHY behind a station-management port. The host writes one 32-bit management frame. In the same clock edge the block decodes the frame as a read or a write to one of 32 PHY registers, performs the access, and raises a one-cycle completion pulse. For a read, the 16-bit result is merged into the low half of the frame register, so the host reads it back from the same place it wrote to. There is no serial pin timing.

The model holds a control word, a status word, an advertisement word, an 8-bit interrupt-pending set and an 8-bit interrupt mask. It answers identification and capability addresses with fixed values. A link input is watched for edges. Each edge updates the link bits of status and raises pending interrupt bits. A level interrupt output reports any pending bit that is enabled in the mask.

Top module: `mgmt_phy_regmodel`

## Requirements
- R1: Frame bit 29 selects a read (1) or a write (0). Bits 27:18 give the register address and bits 15:0 give the write data. After a write the frame register holds the written frame unchanged. After a read it holds the written bits 31:16 with the 16-bit read result in bits 15:0.
- R2: `mii_done` is high for exactly the one cycle after each cycle with `frame_we` high, and is low at all other times.
- R3: After reset the frame register reads 0, `mii_done` and `phy_irq` are 0, and the registers read: control 0x3000, status 0x7809, advertisement 0x01E1, pending 0, mask 0.
- R4: Addresses 2, 3, 5 and 6 read 0x0007, 0xC0D1, 0x0F71 and 0x0001, and writes to them have no effect. Addresses 17, 18, 27, 31 and every address above 31 read 0. A write to an address above 31 changes no register, including the register its low five bits would select.
- R5: A write to address 0 with data bit 15 clear stores the data ANDed with 0x7980 into control. If data bit 12 is set, status bit 5 is also set.
- R6: A write to address 0 with data bit 15 set restores all five registers to their R3 values. Link detection is re-armed, so a link that is high produces the R10 link-up effects one cycle later.
- R7: A write to address 4 stores (data AND 0x2D7F) OR 0x0080 into advertisement.
- R8: A read of address 29 returns the pending bits in bits 7:0 and clears them.
- R9: A write to address 30 stores data bits 7:0 as the mask. A read of address 30 returns the mask.
- R10: A rising edge on `link_up` sets status bits 2 and 5 and raises pending bits 7 and 6. A falling edge clears status bits 2 and 5 and raises pending bit 4. A steady level raises nothing.
- R11: `phy_irq` is high exactly when some pending bit is set whose mask bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_we | input | 1 | Write strobe for the management frame register |
| frame_wdata | input | 32 | Management frame written by the host |
| link_up | input | 1 | Link state from the line side |
| frame_rdata | output | 32 | Current contents of the management frame register |
| mii_done | output | 1 | One-cycle completion pulse after each access |
| phy_irq | output | 1 | Masked PHY interrupt request |

## Verification
A faulty register value stays hidden until it is read back. The bench therefore follows every write and every link edge with reads of the affected addresses, so a wrong control, status or advertisement word shows in `frame_rdata` one cycle after the read strobe. Pending and mask errors also appear on `phy_irq` in the cycle right after the access or link edge that should have changed it. A broken clear-on-read shows on the second read of address 29. Address aliasing above 31 shows when the aliased low register is read back.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;

  localparam int FRAME_W  = 32;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 10;
  localparam int OP_BIT   = 29;
  localparam int ADDR_LSB = 18;
  localparam int NPHY     = 32;
  localparam int IDX_W    = $clog2(NPHY);
  localparam int IRQ_W    = 8;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } mgmt_req_t;

  localparam logic [IDX_W-1:0] RA_CTRL = 5'd0;
  localparam logic [IDX_W-1:0] RA_STAT = 5'd1;
  localparam logic [IDX_W-1:0] RA_ID_HI = 5'd2;
  localparam logic [IDX_W-1:0] RA_ID_LO = 5'd3;
  localparam logic [IDX_W-1:0] RA_ADV  = 5'd4;
  localparam logic [IDX_W-1:0] RA_PEER = 5'd5;
  localparam logic [IDX_W-1:0] RA_EXPN = 5'd6;
  localparam logic [IDX_W-1:0] RA_PEND = 5'd29;
  localparam logic [IDX_W-1:0] RA_MASK = 5'd30;

  localparam logic [DATA_W-1:0] CTRL_INIT = 16'h3000;
  localparam logic [DATA_W-1:0] STAT_INIT = 16'h7809;
  localparam logic [DATA_W-1:0] ADV_INIT  = 16'h01E1;
  localparam logic [DATA_W-1:0] CTRL_KEEP = 16'h7980;
  localparam logic [DATA_W-1:0] ADV_KEEP  = 16'h2D7F;
  localparam logic [DATA_W-1:0] ADV_SET   = 16'h0080;
  localparam logic [DATA_W-1:0] STAT_LINK = 16'h0024;
  localparam logic [DATA_W-1:0] STAT_ANEG = 16'h0020;

  localparam int CTRL_SRST_BIT = 15;
  localparam int CTRL_ANEG_BIT = 12;
  localparam int PI_ENERGY = 7;
  localparam int PI_ANDONE = 6;
  localparam int PI_DOWN   = 4;

  function automatic logic [DATA_W-1:0] ctrl_store(input logic [DATA_W-1:0] v);
    return v & CTRL_KEEP;
  endfunction

  function automatic logic [DATA_W-1:0] adv_store(input logic [DATA_W-1:0] v);
    return (v & ADV_KEEP) | ADV_SET;
  endfunction

  function automatic logic [DATA_W-1:0] fixed_word(input logic [IDX_W-1:0] a);
    case (a)
      RA_ID_HI: return 16'h0007;
      RA_ID_LO: return 16'hC0D1;
      RA_PEER:  return 16'h0F71;
      RA_EXPN:  return 16'h0001;
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/mgmt_frame_decode.sv
module mgmt_frame_decode
  import mgmt_phy_pkg::*;
(
  input  logic [FRAME_W-1:0] frame,
  output mgmt_req_t          req
);
  always_comb begin
    req.rd   = frame[OP_BIT];
    req.addr = frame[ADDR_LSB +: ADDR_W];
    req.data = frame[DATA_W-1:0];
  end
endmodule

// File: rtl/mgmt_link_tracker.sv
module mgmt_link_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic link_in,
  input  logic rearm,
  output logic up_evt,
  output logic dn_evt
);
  logic link_q;

  always_ff @(posedge clk) begin
    if (!rst_n || rearm) link_q <= 1'b0;
    else                 link_q <= link_in;
  end

  assign up_evt = link_in & ~link_q;
  assign dn_evt = ~link_in & link_q;
endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
  import mgmt_phy_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  mgmt_req_t         req,
  input  logic              up_evt,
  input  logic              dn_evt,
  output logic [DATA_W-1:0] rd_data,
  output logic              soft_rst,
  output logic [DATA_W-1:0] stat_o,
  output logic [IRQ_W-1:0]  pend_o,
  output logic [IRQ_W-1:0]  mask_o,
  output logic              irq
);
  logic [DATA_W-1:0] ctrl_q, stat_q, adv_q;
  logic [DATA_W-1:0] ctrl_d, stat_d, adv_d;
  logic [IRQ_W-1:0]  pend_q, mask_q, pend_d, mask_d;
  logic              in_range;
  logic [IDX_W-1:0]  idx;

  assign in_range = (req.addr[ADDR_W-1:IDX_W] == '0);
  assign idx      = req.addr[IDX_W-1:0];

  always_comb begin
    ctrl_d   = ctrl_q;
    stat_d   = stat_q;
    adv_d    = adv_q;
    pend_d   = pend_q;
    mask_d   = mask_q;
    soft_rst = 1'b0;
    if (acc && !req.rd && in_range) begin
      case (idx)
        RA_CTRL: begin
          if (req.data[CTRL_SRST_BIT]) soft_rst = 1'b1;
          else begin
            ctrl_d = ctrl_store(req.data);
            if (req.data[CTRL_ANEG_BIT]) stat_d = stat_d | STAT_ANEG;
          end
        end
        RA_ADV:  adv_d  = adv_store(req.data);
        RA_MASK: mask_d = req.data[IRQ_W-1:0];
        default: ;
      endcase
    end
    if (acc && req.rd && in_range && idx == RA_PEND) pend_d = '0;
    if (soft_rst) begin
      ctrl_d = CTRL_INIT;
      stat_d = STAT_INIT;
      adv_d  = ADV_INIT;
      pend_d = '0;
      mask_d = '0;
    end else begin
      if (up_evt) begin
        stat_d            = stat_d | STAT_LINK;
        pend_d[PI_ENERGY] = 1'b1;
        pend_d[PI_ANDONE] = 1'b1;
      end
      if (dn_evt) begin
        stat_d          = stat_d & ~STAT_LINK;
        pend_d[PI_DOWN] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_INIT;
      stat_q <= STAT_INIT;
      adv_q  <= ADV_INIT;
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      adv_q  <= adv_d;
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (in_range) begin
      case (idx)
        RA_CTRL: rd_data = ctrl_q;
        RA_STAT: rd_data = stat_q;
        RA_ADV:  rd_data = adv_q;
        RA_PEND: rd_data = {{(DATA_W-IRQ_W){1'b0}}, pend_q};
        RA_MASK: rd_data = {{(DATA_W-IRQ_W){1'b0}}, mask_q};
        default: rd_data = fixed_word(idx);
      endcase
    end
  end

  assign stat_o = stat_q;
  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq    = |(pend_q & mask_q);
endmodule

// File: rtl/mgmt_phy_regmodel.sv
module mgmt_phy_regmodel
  import mgmt_phy_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_we,
  input  logic [FRAME_W-1:0] frame_wdata,
  input  logic               link_up,
  output logic [FRAME_W-1:0] frame_rdata,
  output logic               mii_done,
  output logic               phy_irq
);
  mgmt_req_t         req;
  logic [DATA_W-1:0] rd_data;
  logic              soft_rst, link_up_evt, link_dn_evt;
  logic [DATA_W-1:0] stat_q;
  logic [IRQ_W-1:0]  pend_q, mask_q;
  logic [FRAME_W-1:0] frame_q;
  logic              done_q;

  mgmt_frame_decode u_dec (.frame(frame_wdata), .req(req));

  mgmt_link_tracker u_link (
    .clk(clk), .rst_n(rst_n), .link_in(link_up), .rearm(soft_rst),
    .up_evt(link_up_evt), .dn_evt(link_dn_evt)
  );

  mgmt_phy_regs u_regs (
    .clk(clk), .rst_n(rst_n), .acc(frame_we), .req(req),
    .up_evt(link_up_evt), .dn_evt(link_dn_evt), .rd_data(rd_data),
    .soft_rst(soft_rst), .stat_o(stat_q), .pend_o(pend_q), .mask_o(mask_q),
    .irq(phy_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= frame_we;
      if (frame_we)
        frame_q <= req.rd ? {frame_wdata[FRAME_W-1:DATA_W], rd_data} : frame_wdata;
    end
  end

  assign frame_rdata = frame_q;
  assign mii_done    = done_q;
endmodule

// File: rtl/mgmt_phy_regmodel_chk.sv
module mgmt_phy_regmodel_chk
  import mgmt_phy_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               frame_we,
  input logic [FRAME_W-1:0] frame_wdata,
  input logic [FRAME_W-1:0] frame_rdata,
  input logic               mii_done,
  input logic               phy_irq,
  input logic               link_up_evt,
  input logic               link_dn_evt,
  input logic [DATA_W-1:0]  stat_q,
  input logic [IRQ_W-1:0]   pend_q
);
  AST_DONE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_we |=> mii_done); // R2
  AST_DONE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_we |=> !mii_done); // R2
  AST_WRITE_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_we && !frame_wdata[OP_BIT]) |=> frame_rdata == $past(frame_wdata)); // R1
  AST_READ_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_we && frame_wdata[OP_BIT]) |=>
      frame_rdata[FRAME_W-1:DATA_W] == $past(frame_wdata[FRAME_W-1:DATA_W])); // R1
  AST_READ_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_we && frame_wdata[OP_BIT] && frame_wdata[ADDR_LSB +: ADDR_W] == 10'd29
     && !link_up_evt && !link_dn_evt) |=> pend_q == '0); // R8
  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_we && !frame_wdata[OP_BIT] && frame_wdata[ADDR_LSB +: ADDR_W] == 10'd30
     && frame_wdata[IRQ_W-1:0] == '0) |=> !phy_irq); // R11
  AST_LINK_UP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up_evt && !frame_we) |=> (stat_q & STAT_LINK) == STAT_LINK && pend_q[PI_ENERGY]); // R10
  AST_LINK_DOWN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (link_dn_evt && !frame_we) |=> pend_q[PI_DOWN] && (stat_q & STAT_LINK) == '0); // R10
endmodule

bind mgmt_phy_regmodel mgmt_phy_regmodel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_we(frame_we), .frame_wdata(frame_wdata),
  .frame_rdata(frame_rdata), .mii_done(mii_done), .phy_irq(phy_irq),
  .link_up_evt(link_up_evt), .link_dn_evt(link_dn_evt),
  .stat_q(stat_q), .pend_q(pend_q)
);

// File: tb/sim_mgmt_phy_regmodel.sv
module sim_mgmt_phy_regmodel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_we = 1'b0;
  logic [31:0] frame_wdata = '0;
  logic        link_up = 1'b0;
  wire  [31:0] frame_rdata;
  wire         mii_done;
  wire         phy_irq;

  mgmt_phy_regmodel u0 (
    .clk(clk), .rst_n(rst_n), .frame_we(frame_we), .frame_wdata(frame_wdata),
    .link_up(link_up), .frame_rdata(frame_rdata), .mii_done(mii_done),
    .phy_irq(phy_irq)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0] q_exp[$];
  string       q_req[$];

  logic [15:0] m_ctrl, m_stat, m_adv;
  logic [7:0]  m_pend, m_mask;
  logic        m_link;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit rd, input int addr, input logic [15:0] d);
    logic [9:0] a = addr[9:0];
    return {2'b00, rd, 1'b0, a, 2'b00, d};
  endfunction

  function automatic logic [15:0] model_read(input int addr);
    if (addr > 31) return 16'h0;
    case (addr)
      0: return m_ctrl;
      1: return m_stat;
      2: return 16'h0007;
      3: return 16'hC0D1;
      4: return m_adv;
      5: return 16'h0F71;
      6: return 16'h0001;
      29: return {8'h00, m_pend};
      30: return {8'h00, m_mask};
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_ctrl = 16'h3000; m_stat = 16'h7809; m_adv = 16'h01E1;
    m_pend = 8'h00; m_mask = 8'h00;
  endtask

  task automatic access(input string req, input bit rd, input int addr, input logic [15:0] d);
    logic [31:0] f = mk(rd, addr, d);
    logic [31:0] e;
    bit relink = 0;
    e = rd ? {f[31:16], model_read(addr)} : f;
    if (rd && addr == 29) m_pend = 8'h00;
    if (!rd && addr < 32) begin
      case (addr)
        0: if (d[15]) begin model_reset(); relink = m_link; end
           else begin m_ctrl = d & 16'h7980; if (d[12]) m_stat = m_stat | 16'h0020; end
        4: m_adv = (d & 16'h2D7F) | 16'h0080;
        30: m_mask = d[7:0];
        default: ;
      endcase
    end
    q_exp.push_back(e);
    q_req.push_back(req);
    frame_we = 1'b1;
    frame_wdata = f;
    @(negedge clk);
    frame_we = 1'b0;
    if (relink) begin
      @(negedge clk);
      m_stat = m_stat | 16'h0024;
      m_pend = m_pend | 8'hC0;
    end
  endtask

  task automatic set_link(input bit v);
    link_up = v;
    @(negedge clk);
    @(negedge clk);
    if (v && !m_link) begin m_stat = m_stat | 16'h0024; m_pend = m_pend | 8'hC0; end
    if (!v && m_link) begin m_stat = m_stat & ~16'h0024; m_pend = m_pend | 8'h10; end
    m_link = v;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Monitor: pops expected frame contents on every completion pulse.
  always @(negedge clk) begin
    if (rst_n && mii_done) begin
      if (q_exp.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2 completion without access actual=1 expected=0");
      end else begin
        chk({q_req.pop_front(), " frame"}, frame_rdata, q_exp.pop_front());
      end
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    model_reset();
    m_link = 0;
    repeat (3) @(negedge clk);
    chk("R3 frame reset", frame_rdata, 32'h0);
    chk("R3 done reset", {31'b0, mii_done}, 32'h0);
    chk("R3 irq reset", {31'b0, phy_irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    access("R3 ctrl", 1, 0, 16'h0);
    access("R3 stat", 1, 1, 16'h0);
    access("R3 adv", 1, 4, 16'h0);
    access("R3 pend", 1, 29, 16'h0);
    access("R3 mask", 1, 30, 16'h0);
    @(negedge clk);
    chk("R2 single pulse", {31'b0, mii_done}, 32'h0);

    // R4 fixed words, low data bits of the read frame must be replaced (R1)
    access("R4 id2", 1, 2, 16'hA5A5);
    access("R4 id3", 1, 3, 16'hA5A5);
    access("R4 id5", 1, 5, 16'hA5A5);
    access("R4 id6", 1, 6, 16'hA5A5);
    access("R4 unimpl17", 1, 17, 16'hFFFF);
    access("R4 unimpl18", 1, 18, 16'hFFFF);
    access("R4 unimpl27", 1, 27, 16'hFFFF);
    access("R4 unimpl31", 1, 31, 16'hFFFF);
    access("R4 high40", 1, 40, 16'hFFFF);
    access("R4 high1023", 1, 1023, 16'hFFFF);
    access("R1 write frame kept", 0, 17, 16'h1234);
    access("R4 write36", 0, 36, 16'hFFFF);
    access("R4 write32", 0, 32, 16'h7FFF);
    access("R4 write2", 0, 2, 16'hFFFF);
    access("R4 adv untouched", 1, 4, 16'h0);
    access("R4 ctrl untouched", 1, 0, 16'h0);
    access("R4 id2 untouched", 1, 2, 16'h0);

    access("R7 adv all", 0, 4, 16'hFFFF);
    access("R7 adv read", 1, 4, 16'h0);
    access("R7 adv zero", 0, 4, 16'h0000);
    access("R7 adv read0", 1, 4, 16'h0);

    access("R5 ctrl plain", 0, 0, 16'h0100);
    access("R5 ctrl read", 1, 0, 16'h0);
    access("R5 stat kept", 1, 1, 16'h0);
    access("R5 ctrl aneg", 0, 0, 16'h7FFF);
    access("R5 ctrl read2", 1, 0, 16'h0);
    access("R5 stat aneg", 1, 1, 16'h0);

    set_link(1);
    access("R10 stat up", 1, 1, 16'h0);
    chk("R11 irq masked", {31'b0, phy_irq}, 32'h0);
    access("R9 mask wr", 0, 30, 16'h01C0);
    chk("R11 irq enabled", {31'b0, phy_irq}, 32'h1);
    access("R9 mask read", 1, 30, 16'h0);
    access("R8 pend read", 1, 29, 16'h0);
    chk("R11 irq after clear", {31'b0, phy_irq}, 32'h0);
    access("R8 pend cleared", 1, 29, 16'h0);

    set_link(0);
    access("R10 stat down", 1, 1, 16'h0);
    chk("R11 down bit masked", {31'b0, phy_irq}, 32'h0);
    access("R9 mask down", 0, 30, 16'h0010);
    chk("R11 down bit enabled", {31'b0, phy_irq}, 32'h1);
    access("R10 pend down", 1, 29, 16'h0);
    repeat (4) @(negedge clk);
    access("R10 level quiet", 1, 29, 16'h0);

    set_link(1);
    access("R9 mask up", 0, 30, 16'h00FF);
    access("R6 soft reset", 0, 0, 16'h8000);
    access("R6 ctrl", 1, 0, 16'h0);
    access("R6 stat relinked", 1, 1, 16'h0);
    access("R6 adv", 1, 4, 16'h0);
    access("R6 mask", 1, 30, 16'h0);
    chk("R6 irq mask cleared", {31'b0, phy_irq}, 32'h0);
    access("R6 pend relinked", 1, 29, 16'h0);

    repeat (3) @(negedge clk);
    chk("R2 all completions seen", q_exp.size(), 32'h0);
    summary();
  end
endmodule